// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM

This block is a 4096-bit synchronous memory with two fully independent read/write ports, A and B. Each port samples its address, write data, write flag and lane mask into input registers. The array is updated on the following input-clock edge. Read data leaves the block through an output register. A word is 1, 2, 4, 8 or 16 bits wide, chosen by a parameter, and the depth follows so that the total stays at 4096 bits. At 16 bits a two-bit lane mask selects which bytes a write changes.

The clocking scheme is fixed at elaboration. In per-port mode all of a port's registers run from that port's input clock. In split mode the output register of each port runs from a separate output clock. Input registers and output registers each have their own clock enable and their own asynchronous clear. A clear zeroes the registers but leaves the stored words alone.

Top module: `dualclk_ram`

## Requirements
- R1: The word width is one of 1, 2, 4, 8 or 16, and the depth is 4096 divided by the width. At the default width of 16, address 255 is the last word and holds data like any other.
- R2: A port's address, data, write flag and lane mask are taken only at an input-clock edge with that port's input enable high. A write presented while the input enable is low changes no stored word.
- R3: A write captured at input edge k updates the array at input edge k+1. A read captured at edge k appears on the registered output after output edge k+1 (same-frequency clocks).
- R4: At width 16, mask bit 0 guards data bits 7:0 and mask bit 1 guards bits 15:8. A lane whose bit is 0 keeps its old value. At narrower widths the mask is ignored and the whole word is written.
- R5: A write on a port returns, on that port's output, the word's contents from before the write (read-before-write).
- R6: A word written through either port is read back unchanged through the other port, lane by lane, with the most recent write of each lane winning.
- R7: While a port's output enable is low, its output register holds its value whatever is read.
- R8: Asserting a port's output clear drives its output to zero at once, without a clock edge. The stored words are untouched.
- R9: Asserting a port's input clear zeroes its captured address and cancels a captured write that has not yet reached the array.
- R10: In split mode, the output register of a port advances only on that port's output clock. In per-port mode it advances on the port's input clock, and the output clock is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_in | input | 1 | Port A input-register clock (all A registers in per-port mode) |
| clk_a_out | input | 1 | Port A output-register clock in split mode |
| ce_in_a | input | 1 | Port A input-register enable |
| ce_out_a | input | 1 | Port A output-register enable |
| clr_in_a | input | 1 | Port A asynchronous clear of input registers, active high |
| clr_out_a | input | 1 | Port A asynchronous clear of output register, active high |
| we_a | input | 1 | Port A write request |
| addr_a | input | AW | Port A word address |
| din_a | input | WIDTH | Port A write data |
| be_a | input | LANES | Port A byte-lane mask |
| q_a | output | WIDTH | Port A read data |
| clk_b_in | input | 1 | Port B input-register clock (all B registers in per-port mode) |
| clk_b_out | input | 1 | Port B output-register clock in split mode |
| ce_in_b | input | 1 | Port B input-register enable |
| ce_out_b | input | 1 | Port B output-register enable |
| clr_in_b | input | 1 | Port B asynchronous clear of input registers, active high |
| clr_out_b | input | 1 | Port B asynchronous clear of output register, active high |
| we_b | input | 1 | Port B write request |
| addr_b | input | AW | Port B word address |
| din_b | input | WIDTH | Port B write data |
| be_b | input | LANES | Port B byte-lane mask |
| q_b | output | WIDTH | Port B read data |

## Verification
The assertions assume that a clear stays high across at least one edge of the clock it is checked against, so a clear is never a glitch between edges. They also assume that a gated output clock only starts or stops while it is low. The bench raises and drops clears on the falling edge and holds them over a rising edge. It switches the gated output clock only while the base clock is low. The result of both ports writing the same lane of the same word at the same edge is left undefined. The stimulus never does this, so every expected value has one correct answer.

// File: rtl/dualclk_ram_pkg.sv
package dualclk_ram_pkg;

    localparam int MEM_BITS  = 4096;
    localparam int LANE_BITS = 8;

    typedef enum logic {
        CLK_PER_PORT = 1'b0,
        CLK_SPLIT_IO = 1'b1
    } clk_mode_e;

    function automatic int depth_of(input int width);
        return MEM_BITS / width;
    endfunction

    function automatic int lanes_of(input int width);
        return (width >= 2 * LANE_BITS) ? width / LANE_BITS : 1;
    endfunction

    function automatic bit width_ok(input int width);
        return (width == 1) || (width == 2) || (width == 4) ||
               (width == 8) || (width == 16);
    endfunction

endpackage

// File: rtl/dcr_in_stage.sv
module dcr_in_stage #(
    parameter int WIDTH = 16,
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ce,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic [LANES-1:0] be,
    output logic             wr_go,
    output logic [AW-1:0]    wr_addr,
    output logic [WIDTH-1:0] wr_data,
    output logic [LANES-1:0] wr_mask
);

    logic [LANES-1:0] be_eff;
    logic             we_q;
    logic             fresh_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] din_q;
    logic [LANES-1:0] be_q;

    // Lane masking only applies when the word spans several byte lanes.
    generate
        if (LANES > 1) begin : g_masked
            assign be_eff = be;
        end else begin : g_whole
            assign be_eff = be | 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            we_q    <= 1'b0;
            fresh_q <= 1'b0;
            addr_q  <= '0;
            din_q   <= '0;
            be_q    <= '0;
        end else begin
            fresh_q <= ce;
            if (ce) begin
                we_q   <= we;
                addr_q <= addr;
                din_q  <= din;
                be_q   <= be_eff;
            end
        end
    end

    // A captured write fires exactly once, on the edge after capture.
    assign wr_go   = fresh_q & we_q;
    assign wr_addr = addr_q;
    assign wr_data = din_q;
    assign wr_mask = be_q;

endmodule

// File: rtl/dcr_store.sv
module dcr_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic             clk_a,
    input  logic             go_a,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd_a,
    input  logic [LANES-1:0] wm_a,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] rd_a,
    input  logic             clk_b,
    input  logic             go_b,
    input  logic [AW-1:0]    wb,
    input  logic [WIDTH-1:0] wd_b,
    input  logic [LANES-1:0] wm_b,
    input  logic [AW-1:0]    rb,
    output logic [WIDTH-1:0] rd_b
);

    localparam int LW = WIDTH / LANES;

    // One bank per writing port; per-lane tags record which bank is newer.
    // Equal tags: bank A holds the latest lane; different tags: bank B.
    logic [WIDTH-1:0] bank_a [DEPTH];
    logic [WIDTH-1:0] bank_b [DEPTH];
    logic [LANES-1:0] tag_a  [DEPTH];
    logic [LANES-1:0] tag_b  [DEPTH];

    always_ff @(posedge clk_a) begin
        if (go_a) begin
            for (int l = 0; l < LANES; l++) begin
                if (wm_a[l]) begin
                    bank_a[wa][l*LW +: LW] <= wd_a[l*LW +: LW];
                    tag_a[wa][l]           <= tag_b[wa][l];
                end
            end
        end
    end

    always_ff @(posedge clk_b) begin
        if (go_b) begin
            for (int l = 0; l < LANES; l++) begin
                if (wm_b[l]) begin
                    bank_b[wb][l*LW +: LW] <= wd_b[l*LW +: LW];
                    tag_b[wb][l]           <= ~tag_a[wb][l];
                end
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_a[l*LW +: LW] = (tag_a[ra][l] == tag_b[ra][l]) ?
                               bank_a[ra][l*LW +: LW] : bank_b[ra][l*LW +: LW];
            rd_b[l*LW +: LW] = (tag_a[rb][l] == tag_b[rb][l]) ?
                               bank_a[rb][l*LW +: LW] : bank_b[rb][l*LW +: LW];
        end
    end

endmodule

// File: rtl/dcr_out_stage.sv
module dcr_out_stage #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (OUT_REG) begin : g_reg
            logic [WIDTH-1:0] q_r;
            always_ff @(posedge clk or posedge clr) begin
                if (clr) begin
                    q_r <= '0;
                end else if (ce) begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_flow
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/dualclk_ram.sv
module dualclk_ram
    import dualclk_ram_pkg::*;
#(
    parameter int        WIDTH   = 16,
    parameter bit        OUT_REG = 1'b1,
    parameter clk_mode_e MODE    = CLK_SPLIT_IO,
    localparam int       DEPTH   = depth_of(WIDTH),
    localparam int       AW      = $clog2(DEPTH),
    localparam int       LANES   = lanes_of(WIDTH)
) (
    input  logic             clk_a_in,
    input  logic             clk_a_out,
    input  logic             ce_in_a,
    input  logic             ce_out_a,
    input  logic             clr_in_a,
    input  logic             clr_out_a,
    input  logic             we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] din_a,
    input  logic [LANES-1:0] be_a,
    output logic [WIDTH-1:0] q_a,
    input  logic             clk_b_in,
    input  logic             clk_b_out,
    input  logic             ce_in_b,
    input  logic             ce_out_b,
    input  logic             clr_in_b,
    input  logic             clr_out_b,
    input  logic             we_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] din_b,
    input  logic [LANES-1:0] be_b,
    output logic [WIDTH-1:0] q_b
);

    generate
        if (!width_ok(WIDTH)) begin : g_bad_width
            $error("dualclk_ram: WIDTH must be 1, 2, 4, 8 or 16");
        end
    endgenerate

    logic             a_go, b_go;
    logic [AW-1:0]    a_rd_addr, b_rd_addr;
    logic [WIDTH-1:0] a_wdata, b_wdata;
    logic [LANES-1:0] a_mask, b_mask;
    logic [WIDTH-1:0] a_rword, b_rword;
    logic             a_oclk, b_oclk;

    // Output-register clock is chosen once, at elaboration.
    generate
        if (MODE == CLK_SPLIT_IO) begin : g_split
            assign a_oclk = clk_a_out;
            assign b_oclk = clk_b_out;
        end else begin : g_perport
            assign a_oclk = clk_a_in;
            assign b_oclk = clk_b_in;
        end
    endgenerate

    dcr_in_stage #(.WIDTH(WIDTH), .AW(AW), .LANES(LANES)) u_in_a (
        .clk(clk_a_in), .clr(clr_in_a), .ce(ce_in_a), .we(we_a),
        .addr(addr_a), .din(din_a), .be(be_a),
        .wr_go(a_go), .wr_addr(a_rd_addr), .wr_data(a_wdata), .wr_mask(a_mask)
    );

    dcr_in_stage #(.WIDTH(WIDTH), .AW(AW), .LANES(LANES)) u_in_b (
        .clk(clk_b_in), .clr(clr_in_b), .ce(ce_in_b), .we(we_b),
        .addr(addr_b), .din(din_b), .be(be_b),
        .wr_go(b_go), .wr_addr(b_rd_addr), .wr_data(b_wdata), .wr_mask(b_mask)
    );

    dcr_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .LANES(LANES)) u_store (
        .clk_a(clk_a_in), .go_a(a_go), .wa(a_rd_addr), .wd_a(a_wdata),
        .wm_a(a_mask), .ra(a_rd_addr), .rd_a(a_rword),
        .clk_b(clk_b_in), .go_b(b_go), .wb(b_rd_addr), .wd_b(b_wdata),
        .wm_b(b_mask), .rb(b_rd_addr), .rd_b(b_rword)
    );

    dcr_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out_a (
        .clk(a_oclk), .clr(clr_out_a), .ce(ce_out_a), .d(a_rword), .q(q_a)
    );

    dcr_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out_b (
        .clk(b_oclk), .clr(clr_out_b), .ce(ce_out_b), .d(b_rword), .q(q_b)
    );

endmodule

// File: rtl/dualclk_ram_chk.sv
module dualclk_ram_chk
    import dualclk_ram_pkg::*;
#(
    parameter int        WIDTH   = 16,
    parameter int        AW      = 8,
    parameter bit        OUT_REG = 1'b1,
    parameter clk_mode_e MODE    = CLK_SPLIT_IO
) (
    input logic             clk_a_in,
    input logic             clk_a_out,
    input logic             clk_b_in,
    input logic             clk_b_out,
    input logic             ce_in_a,
    input logic             ce_out_a,
    input logic             clr_in_a,
    input logic             clr_out_a,
    input logic             ce_out_b,
    input logic             clr_in_b,
    input logic             clr_out_b,
    input logic [WIDTH-1:0] q_a,
    input logic [WIDTH-1:0] q_b,
    input logic [AW-1:0]    rd_addr_a
);

    logic ock_a, ock_b;
    assign ock_a = (MODE == CLK_SPLIT_IO) ? clk_a_out : clk_a_in;
    assign ock_b = (MODE == CLK_SPLIT_IO) ? clk_b_out : clk_b_in;

    generate
        if (OUT_REG) begin : g_outchk
            // R8: output held at zero while its clear is high
            a_r8_clear_zero_a: assert property (@(posedge ock_a) disable iff (clr_in_a)
                clr_out_a |-> q_a == '0);
            a_r8_clear_zero_b: assert property (@(posedge ock_b) disable iff (clr_in_b)
                clr_out_b |-> q_b == '0);
            // R7: output register frozen while its enable is low
            a_r7_hold_q_a: assert property (@(posedge ock_a) disable iff (clr_out_a)
                !ce_out_a |=> $stable(q_a));
            a_r7_hold_q_b: assert property (@(posedge ock_b) disable iff (clr_out_b)
                !ce_out_b |=> $stable(q_b));
        end
    endgenerate

    // R2: captured address ignores the pins while the input enable is low
    a_r2_addr_hold_a: assert property (@(posedge clk_a_in) disable iff (clr_in_a)
        !ce_in_a |=> $stable(rd_addr_a));

endmodule

bind dualclk_ram dualclk_ram_chk #(
    .WIDTH(WIDTH), .AW(AW), .OUT_REG(OUT_REG), .MODE(MODE)
) u_chk (
    .clk_a_in(clk_a_in), .clk_a_out(clk_a_out),
    .clk_b_in(clk_b_in), .clk_b_out(clk_b_out),
    .ce_in_a(ce_in_a), .ce_out_a(ce_out_a),
    .clr_in_a(clr_in_a), .clr_out_a(clr_out_a),
    .ce_out_b(ce_out_b), .clr_in_b(clr_in_b), .clr_out_b(clr_out_b),
    .q_a(q_a), .q_b(q_b), .rd_addr_a(a_rd_addr)
);

// File: tb/dualclk_ram_test.sv
`timescale 1ns/1ps
module dualclk_ram_test;
    import dualclk_ram_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic run_a = 1'b1, run_b = 1'b1;
    logic clk_a_out, clk_b_out;
    assign clk_a_out = clk & run_a;
    assign clk_b_out = clk & run_b;

    logic        ce_in_a = 1'b1, ce_out_a = 1'b1, clr_in_a = 1'b1, clr_out_a = 1'b1;
    logic        ce_in_b = 1'b1, ce_out_b = 1'b1, clr_in_b = 1'b1, clr_out_b = 1'b1;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [7:0]  addr_a = '0, addr_b = '0;
    logic [15:0] din_a = '0, din_b = '0;
    logic [1:0]  be_a = '0, be_b = '0;
    logic [15:0] q_a, q_b, pq_a, pq_b;

    int checks = 0;
    int errors = 0;

    dualclk_ram #(.WIDTH(16), .OUT_REG(1'b1), .MODE(CLK_SPLIT_IO)) uut (
        .clk_a_in(clk), .clk_a_out(clk_a_out), .ce_in_a(ce_in_a), .ce_out_a(ce_out_a),
        .clr_in_a(clr_in_a), .clr_out_a(clr_out_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .be_a(be_a), .q_a(q_a),
        .clk_b_in(clk), .clk_b_out(clk_b_out), .ce_in_b(ce_in_b), .ce_out_b(ce_out_b),
        .clr_in_b(clr_in_b), .clr_out_b(clr_out_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .be_b(be_b), .q_b(q_b)
    );

    dualclk_ram #(.WIDTH(16), .OUT_REG(1'b1), .MODE(CLK_PER_PORT)) uut_pp (
        .clk_a_in(clk), .clk_a_out(clk_a_out), .ce_in_a(ce_in_a), .ce_out_a(ce_out_a),
        .clr_in_a(clr_in_a), .clr_out_a(clr_out_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .be_a(be_a), .q_a(pq_a),
        .clk_b_in(clk), .clk_b_out(clk_b_out), .ce_in_b(ce_in_b), .ce_out_b(ce_out_b),
        .clr_in_b(clr_in_b), .clr_out_b(clr_out_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .be_b(be_b), .q_b(pq_b)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One port operation: capture edge, then the edge that writes and loads q.
    task automatic op(input bit pb, input bit we, input logic [7:0] ad,
                      input logic [15:0] d, input logic [1:0] be);
        if (pb) begin we_b = we; addr_b = ad; din_b = d; be_b = be; end
        else    begin we_a = we; addr_a = ad; din_a = d; be_a = be; end
        step();
        we_a = 1'b0;
        we_b = 1'b0;
        step();
    endtask

    task automatic t_reset();
        repeat (3) step();
        clr_in_a = 0; clr_out_a = 0; clr_in_b = 0; clr_out_b = 0;
        #1;
        chk("R8 reset q_a", q_a, 16'h0000);
        chk("R8 reset q_b", q_b, 16'h0000);
        chk("R8 reset per-port q_a", pq_a, 16'h0000);
    endtask

    task automatic t_basic();
        op(0, 1, 8'd3, 16'h1234, 2'b11);
        op(0, 0, 8'd3, 16'h0, 2'b00);
        chk("R3 write/read port A", q_a, 16'h1234);
        op(0, 1, 8'd255, 16'hBEEF, 2'b11);
        op(0, 0, 8'd255, 16'h0, 2'b00);
        chk("R1 last address", q_a, 16'hBEEF);
        op(0, 1, 8'd0, 16'hA5A5, 2'b11);
        op(1, 0, 8'd0, 16'h0, 2'b00);
        chk("R6 A write, B read", q_b, 16'hA5A5);
        op(1, 1, 8'd10, 16'h5A5A, 2'b11);
        op(0, 0, 8'd10, 16'h0, 2'b00);
        chk("R6 B write, A read", q_a, 16'h5A5A);
    endtask

    task automatic t_lanes();
        op(0, 1, 8'd20, 16'hFFFF, 2'b11);
        op(0, 1, 8'd20, 16'h1200, 2'b10);
        op(0, 0, 8'd20, 16'h0, 2'b00);
        chk("R4 upper lane only", q_a, 16'h12FF);
        op(1, 1, 8'd20, 16'hEE34, 2'b01);
        op(0, 0, 8'd20, 16'h0, 2'b00);
        chk("R4 R6 lower lane from B", q_a, 16'h1234);
    endtask

    task automatic t_rbw();
        op(0, 1, 8'd30, 16'h1111, 2'b11);
        op(0, 1, 8'd30, 16'h2222, 2'b11);
        chk("R5 old data on write", q_a, 16'h1111);
        op(0, 0, 8'd30, 16'h0, 2'b00);
        chk("R5 new data after write", q_a, 16'h2222);
    endtask

    task automatic t_ce_in();
        op(0, 1, 8'd40, 16'h7777, 2'b11);
        ce_in_a = 1'b0;
        op(0, 1, 8'd40, 16'h9999, 2'b11);
        ce_in_a = 1'b1;
        op(0, 0, 8'd40, 16'h0, 2'b00);
        chk("R2 write ignored with input enable low", q_a, 16'h7777);
    endtask

    task automatic t_ce_out();
        op(0, 0, 8'd3, 16'h0, 2'b00);
        ce_out_a = 1'b0;
        op(0, 0, 8'd255, 16'h0, 2'b00);
        chk("R7 output held", q_a, 16'h1234);
        ce_out_a = 1'b1;
    endtask

    task automatic t_clr_out();
        clr_out_a = 1'b1;
        #1;
        chk("R8 async output clear", q_a, 16'h0000);
        chk("R8 async output clear per-port", pq_a, 16'h0000);
        step();
        clr_out_a = 1'b0;
        op(0, 0, 8'd3, 16'h0, 2'b00);
        chk("R8 array kept after clear", q_a, 16'h1234);
    endtask

    task automatic t_clr_in();
        op(0, 1, 8'd50, 16'h3333, 2'b11);
        we_a = 1'b1; addr_a = 8'd50; din_a = 16'h4444; be_a = 2'b11;
        step();
        we_a = 1'b0;
        clr_in_a = 1'b1;
        step();
        clr_in_a = 1'b0;
        chk("R9 cleared address reads word 0", q_a, 16'hA5A5);
        op(0, 0, 8'd50, 16'h0, 2'b00);
        chk("R9 pending write cancelled", q_a, 16'h3333);
    endtask

    task automatic t_mode();
        run_a = 1'b0;
        op(0, 0, 8'd255, 16'h0, 2'b00);
        chk("R10 split mode waits for output clock", q_a, 16'h3333);
        chk("R10 per-port mode uses input clock", pq_a, 16'hBEEF);
        run_a = 1'b1;
        step();
        chk("R10 split mode after output clock", q_a, 16'hBEEF);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_lanes();
        t_rbw();
        t_ce_in();
        t_ce_out();
        t_clr_out();
        t_clr_in();
        t_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule